// File: doc/BRIEF.md
# Vector Byte Immediate Logic Unit

This block applies one 8-bit immediate to each of the sixteen byte lanes of a 128-bit source vector. It supports four plain bitwise operations and three bit-merge operations. The merge operations also read the current destination vector, so a register-file stage can update a destination in place. The operation arrives already decoded on a 3-bit select. The result is registered and appears one cycle after the request, together with a valid strobe.

The block's control is a two-state machine. The state register holds `IDLE` or `EMIT`. The transitions are:

- `IDLE -> EMIT` (named *accept*) when `req_valid` is high.
- `EMIT -> EMIT` (named *stream*) when `req_valid` stays high.
- `EMIT -> IDLE` (named *drain*) when `req_valid` is low.
- `IDLE -> IDLE` (named *wait*) otherwise.

`res_valid` is high exactly while the state is `EMIT`.

Top module: `vbyte_imm_logic`

## Requirements
- R1: Synchronous active-high reset clears `res_data`, `res_valid` and `res_err` on the next clock edge.
- R2: `res_valid` is high in the cycle after each cycle in which `req_valid` was high, and low otherwise.
- R3: Lane k is bits [8k+7:8k] for k = 0..15, and every lane uses the same immediate.
- R4: Select 0 (AND), 1 (OR) and 3 (XOR) give, for each lane, the source byte combined with the immediate by that operator.
- R5: Select 2 (NOR) gives ~(source | immediate) for each lane.
- R6: Select 4 (move-if-not-zero) gives (src & imm) | (old & ~imm).
- R7: Select 5 (move-if-zero) gives (src & ~imm) | (old & imm).
- R8: Select 6 (select) gives (src & ~old) | (old & imm).
- R9: Selects 0 to 3 ignore the old destination vector.
- R10: Select 7 is unused. It returns the source unchanged and raises `res_err` with the result. `res_err` is low for every other select.
- R11: When `req_valid` is low, `res_data` and `res_err` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Decoded operation select |
| req_imm | input | 8 | Immediate broadcast to all lanes |
| req_src | input | 128 | Source vector |
| req_old | input | 128 | Current destination vector |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 128 | New destination vector |
| res_err | output | 1 | Unused select was given |

## Verification
The bench uses lanes that all differ, so any swapped or misplaced lane byte changes the result. A lane-indexing slip would therefore move bytes between lanes. The merge modes run with an immediate of mixed bits and an old vector distinct from the source. Confusing move-if-zero with move-if-not-zero, or dropping the `~old` term of select, would then give the wrong bits.

The plain modes are run twice with different old vectors; a design that leaked the old destination into them would disagree between the two runs. The bench also checks three more cases:

- **Unused select:** a design that zeroed the output or kept the flag low on select 7 is caught.
- **Idle cycles:** a design that updated its output with no request is caught.
- **Back-to-back requests:** a design whose valid strobe dropped between consecutive requests is caught.

// File: rtl/vbil_pkg.sv
package vbil_pkg;
    localparam int LANE_W = 8;
    localparam int NLANES = 16;
    localparam int VEC_W  = LANE_W * NLANES;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_NOR  = 3'd2,
        OP_XOR  = 3'd3,
        OP_MNZ  = 3'd4,
        OP_MZ   = 3'd5,
        OP_SEL  = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;
endpackage

// File: rtl/vbil_lane.sv
module vbil_lane
    import vbil_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] src,
    input  logic [W-1:0] old,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op_e'(op))
            OP_AND:  res = src & imm;
            OP_OR:   res = src | imm;
            OP_NOR:  res = ~(src | imm);
            OP_XOR:  res = src ^ imm;
            OP_MNZ:  res = (src & imm) | (old & ~imm);
            OP_MZ:   res = (src & ~imm) | (old & imm);
            OP_SEL:  res = (src & ~old) | (old & imm);
            default: res = src;
        endcase
    end
endmodule

// File: rtl/vbil_ctrl.sv
module vbil_ctrl
    import vbil_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic emit
);
    state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb emit = (state_q == ST_EMIT);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> emit);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !emit);
endmodule

// File: rtl/vbyte_imm_logic.sv
module vbyte_imm_logic
    import vbil_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = NLANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [LW-1:0]    req_imm,
    input  logic [LW*NL-1:0] req_src,
    input  logic [LW*NL-1:0] req_old,
    output logic             res_valid,
    output logic [LW*NL-1:0] res_data,
    output logic             res_err
);
    localparam int VW = LW * NL;

    logic [VW-1:0] comb_res;
    logic          emit;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        vbil_lane #(.W(LW)) u_lane (
            .op  (req_op),
            .imm (req_imm),
            .src (req_src[k*LW +: LW]),
            .old (req_old[k*LW +: LW]),
            .res (comb_res[k*LW +: LW])
        );
    end

    vbil_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .emit      (emit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data <= '0;
            res_err  <= 1'b0;
        end else if (req_valid) begin
            res_data <= comb_res;
            res_err  <= (req_op == OP_NONE);
        end
    end

    always_comb res_valid = emit;

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(res_data) && $stable(res_err));
    a_r10_err: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7) |=> (res_err && res_data == $past(req_src)));
    a_r10_noerr: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 3'd7) |=> !res_err);
    a_r4_and: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd0) |=> ((res_data & ~$past(req_src)) == '0));
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_err && res_data == '0));
endmodule

// File: tb/sim_vbyte_imm_logic.sv
module sim_vbyte_imm_logic;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [2:0]   req_op;
    logic [7:0]   req_imm;
    logic [127:0] req_src, req_old;
    logic         res_valid;
    logic [127:0] res_data;
    logic         res_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vbyte_imm_logic u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_imm(req_imm), .req_src(req_src), .req_old(req_old),
        .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
    );

    function automatic logic [127:0] model(input logic [2:0] op, input logic [7:0] im,
                                           input logic [127:0] s, input logic [127:0] o);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] a, b;
            a = s[k*8 +: 8];
            b = o[k*8 +: 8];
            case (op)
                3'd0: r[k*8 +: 8] = a & im;
                3'd1: r[k*8 +: 8] = a | im;
                3'd2: r[k*8 +: 8] = ~(a | im);
                3'd3: r[k*8 +: 8] = a ^ im;
                3'd4: r[k*8 +: 8] = (a & im) | (b & ~im);
                3'd5: r[k*8 +: 8] = (a & ~im) | (b & im);
                3'd6: r[k*8 +: 8] = (a & ~b) | (b & im);
                default: r[k*8 +: 8] = a;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] im,
                         input logic [127:0] s, input logic [127:0] o);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_imm = im; req_src = s; req_old = o;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [7:0] im,
                          input logic [127:0] s, input logic [127:0] o);
        issue(op, im, s, o);
        chk({tag, " valid"}, {127'd0, res_valid}, 128'd1);
        chk({tag, " data"}, res_data, model(op, im, s, o));
        chk({tag, " err"}, {127'd0, res_err}, 128'd0);
    endtask

    localparam logic [127:0] SRC_A = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    localparam logic [127:0] OLD_A = 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f;
    localparam logic [127:0] OLD_B = 128'h33cc55aa0123456789abcdef96693cc3;

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid", {127'd0, res_valid}, 128'd0);
        chk("R1 data", res_data, 128'd0);
        chk("R1 err", {127'd0, res_err}, 128'd0);
    endtask

    task automatic t_plain();
        run_op("R4 and", 3'd0, 8'h5a, SRC_A, OLD_A);
        run_op("R4 or", 3'd1, 8'h81, SRC_A, OLD_A);
        run_op("R4 xor", 3'd3, 8'hff, SRC_A, OLD_A);
        run_op("R5 nor", 3'd2, 8'h3c, SRC_A, OLD_A);
    endtask

    task automatic t_merge();
        run_op("R6 mnz", 3'd4, 8'ha5, SRC_A, OLD_A);
        run_op("R7 mz", 3'd5, 8'ha5, SRC_A, OLD_A);
        run_op("R8 sel", 3'd6, 8'h69, SRC_A, OLD_B);
    endtask

    task automatic t_lanes();
        logic [127:0] s;
        for (int k = 0; k < 16; k++) s[k*8 +: 8] = 8'(k * 17 + 1);
        run_op("R3 lanes", 3'd3, 8'h0f, s, '0);
    endtask

    task automatic t_ignore_old();
        logic [127:0] r1;
        for (int op = 0; op < 4; op++) begin
            issue(3'(op), 8'h96, SRC_A, OLD_A);
            r1 = res_data;
            issue(3'(op), 8'h96, SRC_A, OLD_B);
            chk("R9 old ignored", res_data, r1);
        end
    endtask

    task automatic t_unused();
        issue(3'd7, 8'hff, SRC_A, OLD_A);
        chk("R10 data", res_data, SRC_A);
        chk("R10 err", {127'd0, res_err}, 128'd1);
        run_op("R10 err clears", 3'd0, 8'hff, SRC_A, OLD_A);
    endtask

    task automatic t_hold();
        logic [127:0] prev;
        prev = res_data;
        @(negedge clk);
        req_src = ~SRC_A; req_op = 3'd7;
        @(negedge clk);
        @(negedge clk);
        chk("R11 data held", res_data, prev);
        chk("R11 err held", {127'd0, res_err}, 128'd0);
        chk("R2 valid low idle", {127'd0, res_valid}, 128'd0);
    endtask

    task automatic t_stream();
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_imm = 8'h01; req_src = SRC_A;
        @(negedge clk);
        chk("R2 stream v1", {127'd0, res_valid}, 128'd1);
        chk("R2 stream d1", res_data, model(3'd1, 8'h01, SRC_A, '0));
        req_op = 3'd0; req_imm = 8'hf0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 stream v2", {127'd0, res_valid}, 128'd1);
        chk("R2 stream d2", res_data, model(3'd0, 8'hf0, SRC_A, '0));
        @(negedge clk);
        chk("R2 stream drain", {127'd0, res_valid}, 128'd0);
    endtask

    initial begin
        req_valid = 0; req_op = 0; req_imm = 0; req_src = 0; req_old = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_plain();
        t_merge();
        t_lanes();
        t_ignore_old();
        t_unused();
        t_hold();
        t_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule